// File: doc/BRIEF.md
# Flash-to-FPGA Serial Configuration Loader

This block loads a configuration image from a parallel flash into a target FPGA. It uses the target's passive serial port. Eight images can sit in fixed, equally sized windows of flash. Three slot switches pick the window, and an enable switch decides whether loading from flash happens at all. A load runs as follows:

1. The loader pulses the target's configuration-clear line (`cfg_clear_n`) low.
2. It waits for the target's status line (`tgt_status`) to report ready.
3. It reads the window one 16-bit word at a time over an asynchronous read bus.
4. It shifts each word out one bit per serial clock (`ser_clk`).
5. It stops when the target raises its configured flag (`tgt_cfg_ok`), then adds a fixed run of trailing clocks so the target can finish initialising.

A load starts by itself in the first cycle after reset if the enable switch is on. A reload button also triggers one. While the button is held, the target is kept cleared. When the button is released, a fresh load begins if the enable switch is on.

The status outputs report success (`load_done`) or failure (`load_err`). Failure covers two cases: the target reports an error during the load, or the target never reports configured before the end of the window.

Top module: `ps_image_loader`

## Requirements
- R1: After reset with the enable switch off, `cfg_clear_n`=1, `ser_clk`=0, `flash_oe_n`=1, `load_done`=0 and `load_err`=0, and no serial clock is produced later.
- R2: If the enable switch is on in the first cycle after reset, `cfg_clear_n` goes low for exactly NCFG_CYC cycles and a load follows.
- R3: While the synchronised reload button is high, `cfg_clear_n`=0, `ser_clk`=0, `flash_oe_n`=1 and both status outputs are 0. On release, a load starts if the enable switch is on; otherwise the block stays idle.
- R4: `flash_addr` is a word address. The first read of a load is at slot × 2^SEG_LOG2, and each later read is at the next word. With the defaults this is a 1 MB byte window per slot.
- R5: Each flash read holds `flash_oe_n` low for exactly WAIT_CYC cycles with `flash_addr` stable, and the data is captured at the end of that window.
- R6: Each word is sent low byte first, each byte LSB first, so the word goes out bit 0 to bit 15. `ser_data` changes only while `ser_clk` is low and is stable while it is high.
- R7: No rising edge of `ser_clk` occurs before `tgt_status` has been seen high after `cfg_clear_n` is released.
- R8: Once `tgt_cfg_ok` is seen high, shifting of image data stops. Exactly TAIL_CYC trailing clocks follow (up to three more rising edges in total can occur while the input is synchronised). Then `load_done`=1 and `ser_clk` stays low.
- R9: If `tgt_status` falls during a load, the loader sets `load_err`=1 and `ser_clk` stops.
- R10: If `tgt_cfg_ok` is not seen by the last bit of the window (2^(SEG_LOG2+1) bytes), the loader sets `load_err`=1.
- R11: `load_done` and `load_err` are never both high. Each holds until the reload button is pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_sw | input | 1 | Enable switch for loading from flash |
| slot_sw | input | SLOT_W | Image slot select |
| reload_btn | input | 1 | Reload button, high while pressed |
| flash_data | input | 16 | Flash read data |
| flash_addr | output | AW | Flash word address |
| flash_oe_n | output | 1 | Flash read strobe, active low |
| tgt_status | input | 1 | Target status, high when ready and without error |
| tgt_cfg_ok | input | 1 | Target reports configured |
| cfg_clear_n | output | 1 | Target configuration clear, active low |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| load_done | output | 1 | Load completed |
| load_err | output | 1 | Load failed |

## Verification
The bench checks the main load path with several slot numbers, so base-address decoding and address stepping are both exercised. A target model reports configured after different byte counts: an even count, an odd count that stops partway through a word, and never. These cases separate a stop on the configured flag from a stop at the end of the window. Further runs apply a status drop in mid-load, a button press in mid-load, and a press with the enable switch off. Each run's captured stream is compared byte by byte against words computed from the addresses, which exposes wrong byte order, wrong bit order and wrong addressing.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_HOLD, ST_CLEAR, ST_WAITST, ST_READ,
      ST_SHIFT, ST_TAIL, ST_FIN, ST_FAIL
   } ld_state_t;
endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   if (STAGES < 2) $error("ldr_sync: STAGES must be at least 2");

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= {q[STAGES-2:0], din[i]};
      end
      assign dout[i] = q[STAGES-1];
   end
endmodule

// File: rtl/ldr_flash_rd.sv
module ldr_flash_rd #(
   parameter int AW       = 23,
   parameter int SLOT_W   = 3,
   parameter int SEG_LOG2 = 19,
   parameter int WAIT_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [SLOT_W-1:0] slot,
   input  logic              req,
   input  logic              next,
   input  logic [15:0]       flash_data,
   output logic [AW-1:0]     flash_addr,
   output logic              flash_oe_n,
   output logic [15:0]       word,
   output logic              rdy,
   output logic              last
);
   localparam int CW = $clog2(WAIT_CYC + 1);

   if (SLOT_W + SEG_LOG2 > AW) $error("ldr_flash_rd: address too narrow");
   if (WAIT_CYC < 1)           $error("ldr_flash_rd: WAIT_CYC must be >= 1");

   logic [SLOT_W-1:0]   slot_q;
   logic [SEG_LOG2-1:0] idx;
   logic                busy;
   logic [CW-1:0]       wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         idx    <= '0;
         busy   <= 1'b0;
         wcnt   <= '0;
         word   <= '0;
         rdy    <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (restart) begin
            slot_q <= slot;
            idx    <= '0;
            busy   <= 1'b0;
            wcnt   <= '0;
         end else begin
            if (next) idx <= idx + 1'b1;
            if (req) begin
               busy <= 1'b1;
               wcnt <= '0;
            end else if (busy) begin
               if (wcnt == CW'(WAIT_CYC - 1)) begin
                  busy <= 1'b0;
                  word <= flash_data;
                  rdy  <= 1'b1;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
         end
      end
   end

   assign flash_addr = AW'({slot_q, idx});
   assign flash_oe_n = !busy;
   assign last       = &idx;
endmodule

// File: rtl/ldr_serializer.sv
module ldr_serializer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         halt,
   input  logic [W-1:0] word,
   output logic         ser_clk,
   output logic         ser_data,
   output logic         busy,
   output logic         tick,
   output logic         last_tick
);
   localparam int CW = $clog2(W);

   if (W < 2) $error("ldr_serializer: W must be >= 2");

   logic [W-1:0]  sr;
   logic [CW-1:0] cnt;
   logic          ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         ph   <= 1'b0;
      end else if (halt) begin
         busy <= 1'b0;
         ph   <= 1'b0;
      end else if (load) begin
         sr   <= word;
         cnt  <= '0;
         busy <= 1'b1;
         ph   <= 1'b0;
      end else if (busy) begin
         if (!ph) begin
            ph <= 1'b1;
         end else begin
            ph  <= 1'b0;
            sr  <= sr >> 1;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(W - 1)) busy <= 1'b0;
         end
      end
   end

   assign ser_clk   = busy & ph;
   assign ser_data  = sr[0];
   assign tick      = busy & ph;
   assign last_tick = tick && (cnt == CW'(W - 1));
endmodule

// File: rtl/ps_image_loader.sv
module ps_image_loader
   import ldr_pkg::*;
#(
   parameter int AW          = 23,
   parameter int SLOT_W      = 3,
   parameter int SEG_LOG2    = 19,
   parameter int WAIT_CYC    = 4,
   parameter int NCFG_CYC    = 8,
   parameter int TAIL_CYC    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_sw,
   input  logic [SLOT_W-1:0] slot_sw,
   input  logic              reload_btn,
   input  logic [15:0]       flash_data,
   output logic [AW-1:0]     flash_addr,
   output logic              flash_oe_n,
   input  logic              tgt_status,
   input  logic              tgt_cfg_ok,
   output logic              cfg_clear_n,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              load_done,
   output logic              load_err
);
   localparam int CNT_MAX = (NCFG_CYC > TAIL_CYC) ? NCFG_CYC : TAIL_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (NCFG_CYC < 1) $error("ps_image_loader: NCFG_CYC must be >= 1");
   if (TAIL_CYC < 1) $error("ps_image_loader: TAIL_CYC must be >= 1");

   logic btn_s, cd_s, st_s;
   ldr_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({reload_btn, tgt_cfg_ok, tgt_status}),
      .dout({btn_s, cd_s, st_s})
   );

   logic        rd_restart, rd_req, rd_next, rd_rdy, rd_last;
   logic [15:0] rd_word;
   ldr_flash_rd #(.AW(AW), .SLOT_W(SLOT_W), .SEG_LOG2(SEG_LOG2), .WAIT_CYC(WAIT_CYC)) u_rd (
      .clk(clk), .rst_n(rst_n), .restart(rd_restart), .slot(slot_sw),
      .req(rd_req), .next(rd_next), .flash_data(flash_data),
      .flash_addr(flash_addr), .flash_oe_n(flash_oe_n),
      .word(rd_word), .rdy(rd_rdy), .last(rd_last)
   );

   ld_state_t   state, nxt;
   logic [CNT_W-1:0] cnt;
   logic        pend;
   logic        ser_load, ser_halt, ser_busy, tick, last_tick;
   logic [15:0] ser_word;

   assign ser_word = (state == ST_TAIL) ? 16'h0000 : rd_word;

   ldr_serializer #(.W(16)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(ser_load), .halt(ser_halt), .word(ser_word),
      .ser_clk(ser_clk), .ser_data(ser_data), .busy(ser_busy),
      .tick(tick), .last_tick(last_tick)
   );

   always_comb begin
      nxt        = state;
      ser_load   = 1'b0;
      ser_halt   = 1'b0;
      rd_req     = 1'b0;
      rd_next    = 1'b0;
      rd_restart = 1'b0;
      if (btn_s && state != ST_HOLD) begin
         nxt        = ST_HOLD;
         ser_halt   = 1'b1;
         rd_restart = 1'b1;
      end else begin
         case (state)
            ST_IDLE:   if (pend && en_sw) nxt = ST_CLEAR;
            ST_HOLD: begin
               ser_halt   = 1'b1;
               rd_restart = 1'b1;
               if (!btn_s) nxt = en_sw ? ST_CLEAR : ST_IDLE;
            end
            ST_CLEAR: begin
               rd_restart = 1'b1;
               if (cnt == CNT_W'(NCFG_CYC - 1)) nxt = ST_WAITST;
            end
            ST_WAITST: if (st_s) begin
               rd_req = 1'b1;
               nxt    = ST_READ;
            end
            ST_READ: begin
               if (!st_s)       nxt = ST_FAIL;
               else if (cd_s)   nxt = ST_TAIL;
               else if (rd_rdy) begin
                  ser_load = 1'b1;
                  nxt      = ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (!st_s) begin
                  ser_halt = 1'b1;
                  nxt      = ST_FAIL;
               end else if (tick && cd_s) begin
                  ser_halt = 1'b1;
                  nxt      = ST_TAIL;
               end else if (last_tick) begin
                  if (rd_last) nxt = ST_FAIL;
                  else begin
                     rd_next = 1'b1;
                     rd_req  = 1'b1;
                     nxt     = ST_READ;
                  end
               end
            end
            ST_TAIL: begin
               if (tick && cnt == CNT_W'(TAIL_CYC - 1)) begin
                  ser_halt = 1'b1;
                  nxt      = ST_FIN;
               end else if (!ser_busy) begin
                  ser_load = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         pend  <= 1'b1;
      end else begin
         state <= nxt;
         if (state == ST_IDLE) pend <= 1'b0;
         if (nxt != state)                 cnt <= '0;
         else if (state == ST_CLEAR)       cnt <= cnt + 1'b1;
         else if (state == ST_TAIL && tick) cnt <= cnt + 1'b1;
      end
   end

   assign cfg_clear_n = !(state == ST_HOLD || state == ST_CLEAR);
   assign load_done   = (state == ST_FIN);
   assign load_err    = (state == ST_FAIL);
endmodule

// File: rtl/ps_image_loader_chk.sv
module ps_image_loader_chk #(
   parameter int AW = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] flash_addr,
   input logic          flash_oe_n,
   input logic          cfg_clear_n,
   input logic          ser_clk,
   input logic          ser_data,
   input logic          load_done,
   input logic          load_err
);
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_clear_n |-> (!ser_clk && flash_oe_n && !load_done && !load_err)); // R3

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data)); // R6

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_oe_n && $past(!flash_oe_n)) |-> $stable(flash_addr)); // R5

   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_done && load_err)); // R11

   AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done || load_err) |-> !ser_clk); // R8

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load_done || load_err) && !(load_done || load_err)) |-> !cfg_clear_n); // R11
endmodule

bind ps_image_loader ps_image_loader_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .flash_addr(flash_addr), .flash_oe_n(flash_oe_n),
   .cfg_clear_n(cfg_clear_n), .ser_clk(ser_clk), .ser_data(ser_data),
   .load_done(load_done), .load_err(load_err)
);

// File: tb/ps_image_loader_test.sv
`timescale 1ns/1ps
module ps_image_loader_test;
   localparam int AW = 23, SLOT_W = 3, SEG = 3, WAITC = 3, NCFG = 4, TAIL = 10;
   localparam int NST_DLY = 6;
   localparam int WIN_BYTES = 2 ** (SEG + 1);

   logic clk = 1'b0, rst_n = 1'b0, en_sw = 1'b0, reload_btn = 1'b0;
   logic [SLOT_W-1:0] slot_sw = '0;
   logic [15:0] flash_data;
   logic [AW-1:0] flash_addr;
   logic flash_oe_n, cfg_clear_n, ser_clk, ser_data, load_done, load_err;
   logic tgt_status = 1'b0, tgt_cfg_ok = 1'b0;

   always #2.5 clk = ~clk;

   ps_image_loader #(.AW(AW), .SLOT_W(SLOT_W), .SEG_LOG2(SEG), .WAIT_CYC(WAITC),
                     .NCFG_CYC(NCFG), .TAIL_CYC(TAIL), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .en_sw(en_sw), .slot_sw(slot_sw), .reload_btn(reload_btn),
      .flash_data(flash_data), .flash_addr(flash_addr), .flash_oe_n(flash_oe_n),
      .tgt_status(tgt_status), .tgt_cfg_ok(tgt_cfg_ok), .cfg_clear_n(cfg_clear_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .load_done(load_done), .load_err(load_err)
   );

   function automatic logic [15:0] fword(input logic [AW-1:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'd40503 + 32'h1234;
      return p[15:0];
   endfunction

   assign flash_data = flash_oe_n ? 16'h0000 : fword(flash_addr);

   int nchk = 0, nfail = 0, cyc = 0;
   logic [7:0] exp_q[$];
   int target_len = 0, drop_at = 0;
   int rx = 0, bitn = 0, dly = 0, all_rises = 0, pre_rises = 0, tail_rises = 0;
   int oe_run = 0, oe_first_run = 0, clr_run = 0, clr_len = 0;
   logic [AW-1:0] first_addr = '0;
   logic seen_addr = 1'b0, dropped = 1'b0, ser_clk_q = 1'b0, oe_q = 1'b1, clr_q = 1'b1;
   logic [7:0] byte_sr = '0;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   // target model and monitor, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", cyc, 150000);
         finish_run();
      end
      if (ser_clk && !ser_clk_q) begin
         all_rises++;
         if (!tgt_status) pre_rises++;
         else if (tgt_cfg_ok) tail_rises++;
         else begin
            byte_sr = {ser_data, byte_sr[7:1]};
            bitn++;
            if (bitn == 8) begin
               bitn = 0;
               rx++;
               if (exp_q.size() == 0) chk(1'b0, "R6 byte beyond queue", byte_sr, 0);
               else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  chk(byte_sr == e, "R6 stream byte", byte_sr, e);
               end
               if (target_len != 0 && rx == target_len) tgt_cfg_ok = 1'b1;
               if (drop_at != 0 && rx == drop_at) begin
                  tgt_status = 1'b0;
                  dropped = 1'b1;
               end
            end
         end
      end
      ser_clk_q = ser_clk;
      if (!flash_oe_n) begin
         if (!seen_addr) begin
            first_addr = flash_addr;
            seen_addr = 1'b1;
         end
         oe_run++;
      end else if (!oe_q) begin
         if (oe_first_run == 0) oe_first_run = oe_run;
         oe_run = 0;
      end
      oe_q = flash_oe_n;
      if (!cfg_clear_n) clr_run++;
      else if (!clr_q) begin
         clr_len = clr_run;
         clr_run = 0;
      end
      clr_q = cfg_clear_n;
      if (!cfg_clear_n) begin
         tgt_status = 1'b0; tgt_cfg_ok = 1'b0; dly = 0; rx = 0; bitn = 0;
      end else if (dly < NST_DLY) dly++;
      else if (!dropped) tgt_status = 1'b1;
   end

   // driver side of the scoreboard: expected bytes for a whole window
   task automatic clear_mon(input int slot, input int tlen, input int drop);
      @(posedge clk);
      exp_q.delete();
      for (int w = 0; w < 2 ** SEG; w++) begin
         logic [15:0] d;
         d = fword(AW'((slot << SEG) | w));
         exp_q.push_back(d[7:0]);
         exp_q.push_back(d[15:8]);
      end
      target_len = tlen; drop_at = drop; dropped = 1'b0;
      rx = 0; bitn = 0; pre_rises = 0; tail_rises = 0; all_rises = 0;
      seen_addr = 1'b0; oe_first_run = 0; clr_len = 0; clr_run = 0;
      tgt_status = 1'b0; tgt_cfg_ok = 1'b0; dly = 0;
   endtask

   task automatic do_reset(input logic en, input int slot);
      rst_n = 1'b0; en_sw = en; slot_sw = SLOT_W'(slot);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      int n = 0;
      while (!(load_done || load_err) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 5000, "load end timeout", n, 5000);
   endtask

   initial begin
      int r;
      // R1: reset state with enable off
      clear_mon(3, 0, 0);
      do_reset(1'b0, 3);
      @(negedge clk);
      chk(cfg_clear_n == 1'b1, "R1 clear line idle", cfg_clear_n, 1);
      chk(ser_clk == 1'b0 && flash_oe_n == 1'b1, "R1 clk and strobe idle", {ser_clk, flash_oe_n}, 1);
      chk(!load_done && !load_err, "R1 status low", {load_done, load_err}, 0);
      repeat (100) @(negedge clk);
      chk(all_rises == 0 && flash_oe_n, "R1 no load with enable off", all_rises, 0);

      // R3: button with enable off
      reload_btn = 1'b1;
      repeat (10) @(negedge clk);
      chk(cfg_clear_n == 1'b0, "R3 clear held while pressed", cfg_clear_n, 0);
      reload_btn = 1'b0;
      repeat (60) @(negedge clk);
      chk(cfg_clear_n == 1'b1 && all_rises == 0, "R3 idle after release, enable off", all_rises, 0);

      // R2 R4 R5 R6 R7 R8: power-up load from slot 5, stop after 10 bytes
      clear_mon(5, 10, 0);
      do_reset(1'b1, 5);
      wait_end();
      chk(load_done && !load_err, "R8 done after configured", {load_done, load_err}, 2);
      chk(rx == 10, "R6 bytes received", rx, 10);
      chk(clr_len == NCFG, "R2 clear pulse width", clr_len, NCFG);
      chk(first_addr == AW'(5 << SEG), "R4 slot 5 base address", first_addr, 5 << SEG);
      chk(oe_first_run == WAITC, "R5 strobe width", oe_first_run, WAITC);
      chk(pre_rises == 0, "R7 no clock before status", pre_rises, 0);
      chk(tail_rises >= TAIL && tail_rises <= TAIL + 3, "R8 trailing clocks", tail_rises, TAIL);
      r = all_rises;
      repeat (100) @(negedge clk);
      chk(load_done && all_rises == r, "R11 done held, clock quiet", all_rises, r);

      // R3 R4 R8: reload by button, slot 2, odd byte count
      clear_mon(2, 7, 0);
      slot_sw = 3'd2;
      reload_btn = 1'b1;
      repeat (10) @(negedge clk);
      chk(!load_done && !cfg_clear_n, "R3 status cleared while held", load_done, 0);
      reload_btn = 1'b0;
      wait_end();
      chk(load_done && rx == 7, "R3 reload completes", rx, 7);
      chk(first_addr == AW'(2 << SEG), "R4 slot 2 base address", first_addr, 2 << SEG);
      chk(tail_rises >= TAIL && tail_rises <= TAIL + 3, "R8 trailing clocks odd", tail_rises, TAIL);

      // R10: target never configured, slot 7
      clear_mon(7, 0, 0);
      slot_sw = 3'd7;
      reload_btn = 1'b1; repeat (10) @(negedge clk); reload_btn = 1'b0;
      wait_end();
      chk(load_err && !load_done, "R10 error at window end", {load_done, load_err}, 1);
      chk(rx == WIN_BYTES, "R10 whole window sent", rx, WIN_BYTES);
      chk(first_addr == AW'(7 << SEG), "R4 slot 7 base address", first_addr, 7 << SEG);

      // R9: status drops after 5 bytes, slot 1
      clear_mon(1, 0, 5);
      slot_sw = 3'd1;
      reload_btn = 1'b1; repeat (10) @(negedge clk); reload_btn = 1'b0;
      wait_end();
      chk(load_err && !load_done, "R9 error on status drop", {load_done, load_err}, 1);
      chk(rx == 5, "R9 bytes before drop", rx, 5);
      r = all_rises;
      repeat (60) @(negedge clk);
      chk(all_rises == r && load_err, "R9 clock stopped, R11 error held", all_rises, r);

      // R3: button in mid-load restarts from the window base
      clear_mon(4, 12, 0);
      slot_sw = 3'd4;
      reload_btn = 1'b1; repeat (10) @(negedge clk); reload_btn = 1'b0;
      while (rx < 3) @(negedge clk);
      reload_btn = 1'b1;
      repeat (10) @(negedge clk);
      chk(!cfg_clear_n && !ser_clk && flash_oe_n, "R3 mid-load press clears", cfg_clear_n, 0);
      clear_mon(4, 12, 0);
      reload_btn = 1'b0;
      wait_end();
      chk(load_done && rx == 12, "R3 restarted load completes", rx, 12);
      chk(first_addr == AW'(4 << SEG), "R4 restart base address", first_addr, 4 << SEG);

      finish_run();
   end
endmodule